// File: doc/BRIEF.md
# SDRAM Bank Command Legality Monitor

This block watches the command pins of a four-bank synchronous DRAM every clock and judges each command against the protocol. It decodes the command from the strobe pins, keeps one state machine and one row-open timer per bank, plus device-wide windows for refresh, mode-register programming and activate spacing. When a command is issued to a bank in a state, or at a time, where the protocol forbids it, the block raises a one-cycle violation pulse carrying the bank and a reason code, and bumps a saturating violation counter.

It sits passively beside a memory controller or a bus model, with no influence on the bus. All timing windows are parameters given in clock counts; the defaults correspond to a 7.5 ns clock (activate-to-access 3, precharge 3, activate-to-precharge 7, refresh cycle 10, activate-to-activate across banks 2, write recovery 2, mode-register window 2, burst length 4). A command judged illegal leaves every tracked state unchanged, so the monitor keeps following the legal history of the bus.

Top module: `sdcmd_guard`

## Requirements
- R1: A command is judged only when `cke` was high in the previous cycle; otherwise the cycle counts as a no-operation. With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge, 001 refresh, 000 mode-register set. Deselect (`cs_n` high), no-op and burst stop are never flagged.
- R2: A read or write to a bank that is idle or precharging is flagged with code 3.
- R3: A read or write to an open bank fewer than TRCD cycles after its activate is flagged with code 4; at exactly TRCD cycles it is legal.
- R4: A precharge to an open bank fewer than TRAS cycles after its activate is flagged with code 8.
- R5: An activate fewer than TRRD cycles after the previous accepted activate is flagged with code 7; an activate to a bank that is open is flagged with code 5.
- R6: An activate to a precharging bank is flagged with code 6; a precharge command returns the bank to idle TRP cycles after the command.
- R7: A write lasts BURST_LEN data cycles starting with the command cycle, followed by a recovery lasting until TDPL cycles after the last data; a precharge during write burst or recovery is flagged with code 9. A burst stop ends an ongoing write burst and starts the recovery.
- R8: A refresh or mode-register set while any bank is not idle is flagged with code 11, reporting the lowest-numbered such bank.
- R9: For TRC cycles from an accepted refresh any read, write, activate, precharge, refresh or mode-register set is flagged with code 1; for TMRD cycles from an accepted mode-register set such commands are flagged with code 2.
- R10: `a10` high on a read or write selects auto-precharge: after the read burst (BURST_LEN cycles) or the write burst plus recovery, the bank precharges for TRP cycles and goes idle. A read, write or precharge to a bank with auto-precharge pending is flagged with code 10.
- R11: A precharge with `a10` high targets all banks; it is flagged if any bank would be flagged by a single-bank precharge, reporting the lowest-numbered offending bank and its code. With `a10` low only bank `ba` is judged.
- R12: `viol_pulse` is high for exactly the cycle after the edge that sampled the offending command, with `viol_bank` and `viol_code` valid and both zero otherwise; `viol_count` increments by one per violation and saturates; a flagged command changes no bank or device state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| viol_pulse | output | 1 | One-cycle violation strobe |
| viol_bank | output | 2 | Bank blamed for the violation |
| viol_code | output | 4 | Reason code of the violation |
| viol_count | output | 8 | Saturating violation count |

## Verification
Two rules can meet on a single command: an all-bank precharge while one bank is still inside its activate-to-precharge window and another is not, and a refresh-window rule overlapping a per-bank rule. The bench opens banks at staggered times so an all-bank precharge lands with two offenders, and expects the lower bank and its own code; it also issues an activate inside the refresh window and expects the refresh code in place of any per-bank code. An illegal activate followed by the same activate one cycle later checks that the rejected command left the bank closed.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   typedef enum logic [3:0] {
      C_DESL, C_NOP, C_BST, C_RD, C_WR, C_ACT, C_PRE, C_REF, C_MRS
   } cmd_e;

   typedef enum logic [3:0] {
      B_IDLE, B_ACTV, B_READ, B_WRITE, B_WREC,
      B_RDAP, B_WRAP, B_WRECAP, B_PRE
   } bstate_e;

   typedef enum logic [3:0] {
      RSN_NONE       = 4'd0,
      RSN_REF_BUSY   = 4'd1,
      RSN_MRS_BUSY   = 4'd2,
      RSN_ROW_CLOSED = 4'd3,
      RSN_TRCD       = 4'd4,
      RSN_BANK_OPEN  = 4'd5,
      RSN_TRP        = 4'd6,
      RSN_TRRD       = 4'd7,
      RSN_TRAS       = 4'd8,
      RSN_TDPL       = 4'd9,
      RSN_AP_BUSY    = 4'd10,
      RSN_NOT_IDLE   = 4'd11
   } reason_e;

   function automatic cmd_e decode_pins(logic cs_n, logic ras_n, logic cas_n, logic we_n);
      cmd_e c;
      if (cs_n) c = C_DESL;
      else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  c = C_NOP;
            3'b110:  c = C_BST;
            3'b101:  c = C_RD;
            3'b100:  c = C_WR;
            3'b011:  c = C_ACT;
            3'b010:  c = C_PRE;
            3'b001:  c = C_REF;
            default: c = C_MRS;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
   import sdcmd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   logic cke_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_q <= 1'b0;
      else        cke_q <= cke;
   end

   always_comb begin
      cmd = cke_q ? decode_pins(cs_n, ras_n, cas_n, we_n) : C_NOP;
   end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
   import sdcmd_pkg::*;
#(
   parameter int TRP       = 3,
   parameter int TDPL      = 2,
   parameter int BURST_LEN = 4,
   parameter int SAT       = 7,
   parameter int SW        = 3,
   parameter int TW        = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_act,
   input  logic          go_rd,
   input  logic          go_wr,
   input  logic          go_ap,
   input  logic          go_pre,
   input  logic          go_stop,
   output bstate_e       st,
   output logic [SW-1:0] since_act
);
   localparam logic [SW-1:0] SAT_C = SW'(SAT);
   localparam logic [TW-1:0] RDB_T = TW'(BURST_LEN);
   localparam logic [TW-1:0] WRB_T = TW'(BURST_LEN - 1);
   localparam logic [TW-1:0] DPL_T = TW'(TDPL - 1);
   localparam logic [TW-1:0] PRC_T = TW'(TRP - 1);
   localparam logic [TW-1:0] PRA_T = TW'(TRP);
   localparam bit            WR_LONG = (BURST_LEN > 1);

   logic [TW-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_act <= SAT_C;
      end else if (go_act) begin
         since_act <= SW'(1);
      end else if (since_act != SAT_C) begin
         since_act <= since_act + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= B_IDLE;
         tmr <= '0;
      end else if (go_act) begin
         st  <= B_ACTV;
         tmr <= '0;
      end else if (go_rd) begin
         st  <= go_ap ? B_RDAP : B_READ;
         tmr <= RDB_T;
      end else if (go_wr) begin
         if (WR_LONG) begin
            st  <= go_ap ? B_WRAP : B_WRITE;
            tmr <= WRB_T;
         end else begin
            st  <= go_ap ? B_WRECAP : B_WREC;
            tmr <= DPL_T;
         end
      end else if (go_pre && st != B_IDLE && st != B_PRE) begin
         st  <= B_PRE;
         tmr <= PRC_T;
      end else if (go_stop && st == B_READ) begin
         st  <= B_ACTV;
         tmr <= '0;
      end else if (go_stop && st == B_WRITE) begin
         st  <= B_WREC;
         tmr <= DPL_T;
      end else if (tmr > TW'(1)) begin
         tmr <= tmr - 1'b1;
      end else begin
         tmr <= '0;
         case (st)
            B_READ:   st <= B_ACTV;
            B_WREC:   st <= B_ACTV;
            B_PRE:    st <= B_IDLE;
            B_WRITE:  begin st <= B_WREC;   tmr <= DPL_T; end
            B_WRAP:   begin st <= B_WRECAP; tmr <= DPL_T; end
            B_RDAP:   begin st <= B_PRE;    tmr <= PRA_T; end
            B_WRECAP: begin st <= B_PRE;    tmr <= PRA_T; end
            default:  st <= st;
         endcase
      end
   end
endmodule

// File: rtl/sdcmd_device.sv
module sdcmd_device #(
   parameter int TRC  = 10,
   parameter int TMRD = 2,
   parameter int TRRD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_ref,
   input  logic go_mrs,
   input  logic go_act,
   output logic ref_busy,
   output logic mrs_busy,
   output logic rrd_ok
);
   localparam int DW = $clog2((TRC > TMRD ? TRC : TMRD) + 1);
   localparam int GW = $clog2(TRRD + 1);
   localparam logic [DW-1:0] REF_T  = DW'(TRC - 1);
   localparam logic [DW-1:0] MRS_T  = DW'(TMRD - 1);
   localparam logic [GW-1:0] TRRD_C = GW'(TRRD);

   logic [DW-1:0] ref_t, mrs_t;
   logic [GW-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_t <= '0;
         mrs_t <= '0;
         gap   <= TRRD_C;
      end else begin
         if (go_ref)            ref_t <= REF_T;
         else if (ref_t != '0)  ref_t <= ref_t - 1'b1;
         if (go_mrs)            mrs_t <= MRS_T;
         else if (mrs_t != '0)  mrs_t <= mrs_t - 1'b1;
         if (go_act)            gap <= GW'(1);
         else if (gap != TRRD_C) gap <= gap + 1'b1;
      end
   end

   assign ref_busy = (ref_t != '0);
   assign mrs_busy = (mrs_t != '0);
   assign rrd_ok   = (gap >= TRRD_C);
endmodule

// File: rtl/sdcmd_judge.sv
module sdcmd_judge
   import sdcmd_pkg::*;
#(
   parameter int BANKS = 4,
   parameter int BA_W  = 2,
   parameter int TRCD  = 3,
   parameter int TRAS  = 7,
   parameter int SW    = 3
) (
   input  cmd_e            cmd,
   input  logic [BA_W-1:0] ba,
   input  logic            a10,
   input  bstate_e         st_v    [BANKS],
   input  logic [SW-1:0]   since_v [BANKS],
   input  logic            ref_busy,
   input  logic            mrs_busy,
   input  logic            rrd_ok,
   output logic            bad,
   output logic [BA_W-1:0] bad_bank,
   output reason_e         bad_code
);
   localparam logic [SW-1:0] TRCD_C = SW'(TRCD);
   localparam logic [SW-1:0] TRAS_C = SW'(TRAS);

   function automatic reason_e pre_fault(bstate_e s, logic [SW-1:0] since);
      case (s)
         B_RDAP, B_WRAP, B_WRECAP: return RSN_AP_BUSY;
         B_WRITE, B_WREC:          return RSN_TDPL;
         B_ACTV, B_READ:           return (since < TRAS_C) ? RSN_TRAS : RSN_NONE;
         default:                  return RSN_NONE;
      endcase
   endfunction

   function automatic reason_e access_fault(bstate_e s, logic [SW-1:0] since);
      case (s)
         B_RDAP, B_WRAP, B_WRECAP: return RSN_AP_BUSY;
         B_IDLE, B_PRE:            return RSN_ROW_CLOSED;
         default:                  return (since < TRCD_C) ? RSN_TRCD : RSN_NONE;
      endcase
   endfunction

   function automatic reason_e act_fault(bstate_e s);
      case (s)
         B_IDLE:  return RSN_NONE;
         B_PRE:   return RSN_TRP;
         default: return RSN_BANK_OPEN;
      endcase
   endfunction

   logic    heavy;
   reason_e r;

   always_comb begin
      heavy    = (cmd != C_DESL) && (cmd != C_NOP) && (cmd != C_BST);
      bad_code = RSN_NONE;
      bad_bank = ba;
      r        = RSN_NONE;
      if (heavy && ref_busy) begin
         bad_code = RSN_REF_BUSY;
      end else if (heavy && mrs_busy) begin
         bad_code = RSN_MRS_BUSY;
      end else begin
         case (cmd)
            C_RD, C_WR: bad_code = access_fault(st_v[ba], since_v[ba]);
            C_ACT: begin
               bad_code = act_fault(st_v[ba]);
               if (bad_code == RSN_NONE && !rrd_ok) bad_code = RSN_TRRD;
            end
            C_PRE: begin
               if (a10) begin
                  for (int i = BANKS - 1; i >= 0; i--) begin
                     r = pre_fault(st_v[i], since_v[i]);
                     if (r != RSN_NONE) begin
                        bad_code = r;
                        bad_bank = BA_W'(i);
                     end
                  end
               end else begin
                  bad_code = pre_fault(st_v[ba], since_v[ba]);
               end
            end
            C_REF, C_MRS: begin
               for (int i = BANKS - 1; i >= 0; i--) begin
                  if (st_v[i] != B_IDLE) begin
                     bad_code = RSN_NOT_IDLE;
                     bad_bank = BA_W'(i);
                  end
               end
            end
            default: bad_code = RSN_NONE;
         endcase
      end
      bad = (bad_code != RSN_NONE);
   end
endmodule

// File: rtl/sdcmd_guard.sv
module sdcmd_guard
   import sdcmd_pkg::*;
#(
   parameter int BANKS     = 4,
   parameter int TRCD      = 3,
   parameter int TRAS      = 7,
   parameter int TRP       = 3,
   parameter int TRC       = 10,
   parameter int TRRD      = 2,
   parameter int TDPL      = 2,
   parameter int TMRD      = 2,
   parameter int BURST_LEN = 4,
   parameter int CNT_W     = 8,
   localparam int BA_W     = $clog2(BANKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [BA_W-1:0]  ba,
   input  logic             a10,
   output logic             viol_pulse,
   output logic [BA_W-1:0]  viol_bank,
   output logic [3:0]       viol_code,
   output logic [CNT_W-1:0] viol_count
);
   localparam int SAT  = (TRAS > TRCD) ? TRAS : TRCD;
   localparam int SW   = $clog2(SAT + 1);
   localparam int TMAX = (BURST_LEN > TRP) ? ((BURST_LEN > TDPL) ? BURST_LEN : TDPL)
                                           : ((TRP > TDPL) ? TRP : TDPL);
   localparam int TW   = $clog2(TMAX + 1);

   if (BANKS < 2 || (1 << BA_W) != BANKS) begin : g_chk_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (TRP < 2 || TDPL < 2 || TRC < 2 || TMRD < 2) begin : g_chk_win
      $error("TRP, TDPL, TRC and TMRD must be at least 2");
   end
   if (TRCD < 1 || TRRD < 1 || BURST_LEN < 1 || TRAS < TRCD) begin : g_chk_act
      $error("TRCD, TRRD, BURST_LEN must be positive and TRAS >= TRCD");
   end

   cmd_e          cmd;
   bstate_e       st_v    [BANKS];
   logic [SW-1:0] since_v [BANKS];
   logic          ref_busy, mrs_busy, rrd_ok;
   logic          bad, ok;
   logic [BA_W-1:0] bad_bank;
   reason_e       bad_code;

   sdcmd_decode u_dec (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
   );

   sdcmd_judge #(
      .BANKS(BANKS), .BA_W(BA_W), .TRCD(TRCD), .TRAS(TRAS), .SW(SW)
   ) u_judge (
      .cmd(cmd), .ba(ba), .a10(a10), .st_v(st_v), .since_v(since_v),
      .ref_busy(ref_busy), .mrs_busy(mrs_busy), .rrd_ok(rrd_ok),
      .bad(bad), .bad_bank(bad_bank), .bad_code(bad_code)
   );

   assign ok = !bad;

   sdcmd_device #(.TRC(TRC), .TMRD(TMRD), .TRRD(TRRD)) u_dev (
      .clk(clk), .rst_n(rst_n),
      .go_ref(ok && cmd == C_REF),
      .go_mrs(ok && cmd == C_MRS),
      .go_act(ok && cmd == C_ACT),
      .ref_busy(ref_busy), .mrs_busy(mrs_busy), .rrd_ok(rrd_ok)
   );

   for (genvar i = 0; i < BANKS; i++) begin : g_bank
      logic hit, rdwr;
      assign hit  = (ba == BA_W'(i));
      assign rdwr = ok && (cmd == C_RD || cmd == C_WR);
      sdcmd_bank #(
         .TRP(TRP), .TDPL(TDPL), .BURST_LEN(BURST_LEN),
         .SAT(SAT), .SW(SW), .TW(TW)
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .go_act(ok && cmd == C_ACT && hit),
         .go_rd(ok && cmd == C_RD && hit),
         .go_wr(ok && cmd == C_WR && hit),
         .go_ap(a10),
         .go_pre(ok && cmd == C_PRE && (a10 || hit)),
         .go_stop((cmd == C_BST) || (rdwr && !hit)),
         .st(st_v[i]),
         .since_act(since_v[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_pulse <= 1'b0;
         viol_bank  <= '0;
         viol_code  <= '0;
         viol_count <= '0;
      end else begin
         viol_pulse <= bad;
         viol_bank  <= bad ? bad_bank : '0;
         viol_code  <= bad ? bad_code : RSN_NONE;
         if (bad && viol_count != '1) viol_count <= viol_count + 1'b1;
      end
   end
endmodule

// File: rtl/sdcmd_guard_chk.sv
module sdcmd_guard_chk #(
   parameter int BA_W  = 2,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cke,
   input logic             cs_n,
   input logic             ras_n,
   input logic             cas_n,
   input logic             viol_pulse,
   input logic [BA_W-1:0]  viol_bank,
   input logic [3:0]       viol_code,
   input logic [CNT_W-1:0] viol_count
);
   AST_CKE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> $past(cke, 2)); // R1

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> !viol_pulse); // R1

   AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cs_n) && $past(ras_n) && $past(cas_n)) |-> !viol_pulse); // R1

   AST_PULSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> (viol_code != 4'd0)); // R12

   AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !viol_pulse |-> (viol_code == 4'd0 && viol_bank == '0)); // R12

   AST_COUNT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_count != $past(viol_count)) |-> viol_pulse); // R12

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse && $past(viol_count) != '1) |-> (viol_count == $past(viol_count) + 1'b1)); // R12
endmodule

bind sdcmd_guard sdcmd_guard_chk #(.BA_W(BA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
   .cas_n(cas_n), .viol_pulse(viol_pulse), .viol_bank(viol_bank),
   .viol_code(viol_code), .viol_count(viol_count)
);

// File: tb/sdcmd_guard_tb_top.sv
module sdcmd_guard_tb_top;
   localparam logic [3:0] K_DESL = 4'b1000, K_NOP = 4'b0111, K_BST = 4'b0110,
                          K_RD   = 4'b0101, K_WR  = 4'b0100, K_ACT = 4'b0011,
                          K_PRE  = 4'b0010, K_REF = 4'b0001, K_MRS = 4'b0000;
   localparam int E_REF = 1, E_MRS = 2, E_CLOSED = 3, E_TRCD = 4, E_OPEN = 5,
                  E_TRP = 6, E_TRRD = 7, E_TRAS = 8, E_TDPL = 9, E_AP = 10,
                  E_NIDLE = 11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b1;
   logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic       a10 = 1'b0;
   logic       viol_pulse;
   logic [1:0] viol_bank;
   logic [3:0] viol_code;
   logic [7:0] viol_count;

   int n_chk = 0, n_fail = 0, n_viol = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sdcmd_guard dut_i (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
      .viol_pulse(viol_pulse), .viol_bank(viol_bank),
      .viol_code(viol_code), .viol_count(viol_count)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(logic [3:0] k, logic [1:0] b, logic a);
      @(negedge clk);
      cke = 1'b1;
      {cs_n, ras_n, cas_n, we_n} = k;
      ba = b;
      a10 = a;
   endtask

   task automatic issue(string req, logic [3:0] k, logic [1:0] b, logic a, int code, logic [1:0] eb);
      drive(k, b, a);
      @(posedge clk);
      #1;
      if (code != 0) n_viol++;
      check(req, {25'd0, viol_pulse, viol_bank, viol_code},
            {25'd0, (code != 0), (code != 0) ? eb : 2'd0, code[3:0]});
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         drive(K_NOP, 2'd0, 1'b0);
         @(posedge clk);
      end
   endtask

   task automatic close_all();
      idle(8);
      issue("R11 all-bank precharge clean", K_PRE, 2'd0, 1'b1, 0, 2'd0);
      idle(4);
   endtask

   task automatic t_reset();
      #1;
      check("R12 reset pulse", {31'd0, viol_pulse}, 32'd0);
      check("R12 reset count", {24'd0, viol_count}, 32'd0);
   endtask

   task automatic t_rowcycle();
      issue("R2 read idle bank", K_RD, 2'd0, 1'b0, E_CLOSED, 2'd0);
      issue("R12 pulse one cycle", K_NOP, 2'd0, 1'b0, 0, 2'd0);
      issue("R3 activate", K_ACT, 2'd0, 1'b0, 0, 2'd0);
      idle(1);
      issue("R3 read early", K_RD, 2'd0, 1'b0, E_TRCD, 2'd0);
      issue("R3 read at TRCD", K_RD, 2'd0, 1'b0, 0, 2'd0);
      issue("R4 precharge early", K_PRE, 2'd0, 1'b0, E_TRAS, 2'd0);
      idle(2);
      issue("R4 precharge at TRAS", K_PRE, 2'd0, 1'b0, 0, 2'd0);
      idle(1);
      issue("R6 activate while precharging", K_ACT, 2'd0, 1'b0, E_TRP, 2'd0);
      issue("R6 activate after TRP", K_ACT, 2'd0, 1'b0, 0, 2'd0);
      close_all();
   endtask

   task automatic t_rrd();
      issue("R5 activate b1", K_ACT, 2'd1, 1'b0, 0, 2'd0);
      issue("R5 activate b2 early", K_ACT, 2'd2, 1'b0, E_TRRD, 2'd2);
      issue("R12 rejected activate left b2 closed", K_ACT, 2'd2, 1'b0, 0, 2'd0);
      issue("R5 activate open bank", K_ACT, 2'd1, 1'b0, E_OPEN, 2'd1);
      close_all();
   endtask

   task automatic t_write();
      issue("R7 activate", K_ACT, 2'd1, 1'b0, 0, 2'd0);
      idle(7);
      issue("R7 write", K_WR, 2'd1, 1'b0, 0, 2'd0);
      idle(3);
      issue("R7 precharge in recovery", K_PRE, 2'd1, 1'b0, E_TDPL, 2'd1);
      issue("R7 precharge after recovery", K_PRE, 2'd1, 1'b0, 0, 2'd0);
      idle(3);
      issue("R7 activate again", K_ACT, 2'd1, 1'b0, 0, 2'd0);
      idle(7);
      issue("R7 write 2", K_WR, 2'd1, 1'b0, 0, 2'd0);
      issue("R1 burst stop legal", K_BST, 2'd0, 1'b0, 0, 2'd0);
      issue("R7 precharge after stop", K_PRE, 2'd1, 1'b0, E_TDPL, 2'd1);
      issue("R7 precharge after stop recovery", K_PRE, 2'd1, 1'b0, 0, 2'd0);
      idle(3);
   endtask

   task automatic t_autopre();
      issue("R10 activate", K_ACT, 2'd3, 1'b0, 0, 2'd0);
      idle(2);
      issue("R10 read auto-precharge", K_RD, 2'd3, 1'b1, 0, 2'd0);
      issue("R10 read during auto-precharge", K_RD, 2'd3, 1'b0, E_AP, 2'd3);
      issue("R10 precharge during auto-precharge", K_PRE, 2'd3, 1'b0, E_AP, 2'd3);
      idle(4);
      issue("R10 activate before idle", K_ACT, 2'd3, 1'b0, E_TRP, 2'd3);
      issue("R10 activate after auto-precharge", K_ACT, 2'd3, 1'b0, 0, 2'd0);
      close_all();
   endtask

   task automatic t_refmrs();
      issue("R8 activate b2", K_ACT, 2'd2, 1'b0, 0, 2'd0);
      idle(1);
      issue("R8 activate b1", K_ACT, 2'd1, 1'b0, 0, 2'd0);
      issue("R8 refresh banks open", K_REF, 2'd0, 1'b0, E_NIDLE, 2'd1);
      issue("R8 mode set banks open", K_MRS, 2'd0, 1'b0, E_NIDLE, 2'd1);
      close_all();
      issue("R9 refresh", K_REF, 2'd0, 1'b0, 0, 2'd0);
      issue("R1 nop in refresh", K_NOP, 2'd0, 1'b0, 0, 2'd0);
      issue("R1 burst stop in refresh", K_BST, 2'd0, 1'b0, 0, 2'd0);
      idle(6);
      issue("R9 activate in refresh", K_ACT, 2'd0, 1'b0, E_REF, 2'd0);
      issue("R9 activate after TRC", K_ACT, 2'd0, 1'b0, 0, 2'd0);
      close_all();
      issue("R9 mode set", K_MRS, 2'd0, 1'b0, 0, 2'd0);
      issue("R9 activate in mode window", K_ACT, 2'd0, 1'b0, E_MRS, 2'd0);
      issue("R9 activate after TMRD", K_ACT, 2'd0, 1'b0, 0, 2'd0);
      close_all();
   endtask

   task automatic t_pall();
      issue("R11 activate b3", K_ACT, 2'd3, 1'b0, 0, 2'd0);
      idle(7);
      issue("R11 activate b1", K_ACT, 2'd1, 1'b0, 0, 2'd0);
      idle(1);
      issue("R11 activate b2", K_ACT, 2'd2, 1'b0, 0, 2'd0);
      issue("R11 all-bank precharge two offenders", K_PRE, 2'd3, 1'b1, E_TRAS, 2'd1);
      close_all();
   endtask

   task automatic t_cke();
      @(negedge clk);
      cke = 1'b0;
      {cs_n, ras_n, cas_n, we_n} = K_NOP;
      @(posedge clk);
      issue("R1 command after cke low ignored", K_RD, 2'd0, 1'b0, 0, 2'd0);
      issue("R1 same command with cke high", K_RD, 2'd0, 1'b0, E_CLOSED, 2'd0);
      issue("R1 deselect ignored", K_DESL, 2'd0, 1'b0, 0, 2'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      t_rowcycle();
      t_rrd();
      t_write();
      t_autopre();
      t_refmrs();
      t_pall();
      t_cke();
      idle(1);
      check("R12 violation count", {24'd0, viol_count}, n_viol);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R12 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule